// File: doc/BRIEF.md
# Sideband Wire Host Controller Register Front End

This block is the memory-mapped register face of a host controller for a single-wire sideband management bus. Software programs configuration, a target address, write and read byte counts and up to 32 outgoing bytes over a plain 32-bit register bus (address, write enable, write data, combinational read data). It then fires a command. The block hands the transaction to a separate wire engine and takes back the engine's result flags, captured check bytes, negotiation result and received bytes when the engine reports completion. A level interrupt is raised from the enabled status bits.

Each direction's 32-byte buffer is split into two 16-byte banks that sit at separate places in the address map. Within each word the bytes are little-endian. The engine sees each buffer as one flat byte vector.

The launch toward the engine is a valid/ready handshake. `eng_start_valid` rises the cycle after a fire is accepted. It then stays high, holding the transaction in place, until the cycle in which `eng_start_ready` is sampled high. The engine may hold off (back-pressure) for as long as it likes. Completion is a one-cycle `eng_done` pulse, and it is honoured only after the launch has been accepted and while a transaction is outstanding.

Top module: `sbw_host_regs`

## Requirements
- R1: After reset, the control word reads 0x0008_0000 (sampling point 8), the timing word reads 0x0000_0101 (both timing fields 1), interrupt status reads 0, `irq` is low and `eng_start_valid` is low.
- R2: Only the defined fields are stored, and undefined bits read 0. The masks are: control 0x000F_3FF1 at 0x00, timing 0x0000_FFFF at 0x04, length 0x80FF_FFFF at 0x0C, expected check bytes 0x00FF_FFFF at 0x10, interrupt control 0xC000_001F at 0x18 (bits 31:30 negotiation mode, bits 4:0 enables).
- R3: A write or read length field (length word bits 15:8 and 23:16) above 32 is stored as 32. The target address is in bits 7:0 and the automatic check enable is in bit 31.
- R4: Outgoing byte n (0..15) is in the word at 0x20+4*(n div 4), and byte n (16..31) is in the word at 0x40+4*((n-16) div 4). In both banks it sits at lane n mod 4, bits 8*(n mod 4)+7 down to 8*(n mod 4). Byte n drives `eng_tx_data` bits 8n+7:8n.
- R5: Writing the command word (0x08) with bit 0 set while idle raises `eng_start_valid` on the next cycle and holds it until `eng_start_ready` is sampled high.
- R6: A fire while a transaction is outstanding is ignored: no new launch and no change to command bit 0. Writing the command word with bit 0 clear clears the latched fire bit and does not end the transaction.
- R7: An accepted `eng_done` sets status bit 0 (done) every time and ORs `eng_flags[3:0]` into status bits 4:1 (write-check abort, write-check bad, bus connect, bus timeout). It loads status bits 29:16 with `eng_nego_result`. It captures the received bytes and check bytes. A `eng_done` with no accepted transaction outstanding changes nothing.
- R8: Incoming byte n is read at 0x30 (bytes 0..15) and 0x50 (bytes 16..31), using the same lane mapping as R4. These words ignore bus writes.
- R9: Writing 1s to status bits 4:0 at 0x1C clears those bits. If a completion sets a bit in the same cycle, the set wins.
- R10: `irq` is high exactly when some status bit 4:0 is set whose enable bit at 0x18 is also set.
- R11: The command word reads the pin monitor in bit 31, the engine state in bits 27:24 and the latched fire bit in bit 0.
- R12: The captured check word at 0x14 reads the received-data check byte in bits 23:16 and the write check byte in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cfg_ctrl | output | 32 | Stored control word |
| cfg_timing | output | 16 | Message timing (15:8) and address timing (7:0) |
| cfg_nego_mode | output | 2 | Negotiation mode select |
| cfg_exp_fcs | output | 24 | Expected check bytes |
| eng_target | output | 8 | Target address |
| eng_wr_len | output | 8 | Write byte count |
| eng_rd_len | output | 8 | Read byte count |
| eng_auto_fcs | output | 1 | Automatic check for address-write |
| eng_tx_data | output | 256 | Outgoing bytes, byte n at bits 8n+7:8n |
| eng_start_valid | output | 1 | Transaction launch request |
| eng_start_ready | input | 1 | Engine accepts launch |
| eng_done | input | 1 | Engine completion pulse |
| eng_flags | input | 4 | Result flags for status bits 4:1 |
| eng_nego_result | input | 14 | Timing negotiation result |
| eng_cap_wfcs | input | 8 | Captured write check byte |
| eng_cap_rfcs | input | 8 | Captured read check byte |
| eng_rx_data | input | 256 | Incoming bytes, byte n at bits 8n+7:8n |
| eng_state | input | 4 | Engine state code |
| eng_pin_mon | input | 1 | Wire pin monitor |
| irq | output | 1 | Level interrupt |

## Verification
Several rules are checked on every cycle: a launch request holds until it is accepted, no request appears without an outstanding transaction, an accepted completion always leaves the done bit set, a write-1-to-clear with no competing completion clears the done bit, and the stored lengths never exceed 32. Other behaviour can only be shown by the bench's scenarios. That covers the register masks and reset values, the split-bank byte placement in both directions, the ignored second fire and the fire-bit clear during a transaction, the completion that is dropped when idle, set-over-clear priority, and interrupt masking under different enable patterns.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int AW        = 8;
  localparam int DW        = 32;
  localparam int BUF_BYTES = 32;
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int WIDX_W    = $clog2(BUF_WORDS);
  localparam int LEN_W     = 8;
  localparam int NSTS      = 5;
  localparam int NEGO_W    = 14;

  localparam logic [AW-1:0] A_CTRL   = 8'h00;
  localparam logic [AW-1:0] A_TIMING = 8'h04;
  localparam logic [AW-1:0] A_CMD    = 8'h08;
  localparam logic [AW-1:0] A_LEN    = 8'h0C;
  localparam logic [AW-1:0] A_EXPFCS = 8'h10;
  localparam logic [AW-1:0] A_CAPFCS = 8'h14;
  localparam logic [AW-1:0] A_INTCTL = 8'h18;
  localparam logic [AW-1:0] A_INTSTS = 8'h1C;

  localparam logic [DW-1:0] CTRL_MASK   = 32'h000F_3FF1;
  localparam logic [DW-1:0] CTRL_RST    = 32'h0008_0000;
  localparam logic [DW-1:0] TIMING_MASK = 32'h0000_FFFF;
  localparam logic [DW-1:0] TIMING_RST  = 32'h0000_0101;
  localparam logic [DW-1:0] LEN_MASK    = 32'h80FF_FFFF;
  localparam logic [DW-1:0] EXP_MASK    = 32'h00FF_FFFF;
  localparam logic [DW-1:0] INTCTL_MASK = 32'hC000_001F;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    return (v > LEN_W'(BUF_BYTES)) ? LEN_W'(BUF_BYTES) : v;
  endfunction
endpackage

// File: rtl/sbw_word_buf.sv
module sbw_word_buf #(
  parameter int WORDS = 8,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [31:0]         wr_data,
  input  logic                ld_en,
  input  logic [WORDS*32-1:0] ld_data,
  output logic [WORDS*32-1:0] flat
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  word_q <= '0;
      else if (ld_en)                              word_q <= ld_data[w*32 +: 32];
      else if (wr_en && (wr_idx == IW'(w)))        word_q <= wr_data;
    end
    assign flat[w*32 +: 32] = word_q;
  end
endmodule

// File: rtl/sbw_launch_ctl.sv
module sbw_launch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_req,
  input  logic fire_clr,
  input  logic start_ready,
  input  logic done,
  output logic start_valid,
  output logic busy,
  output logic fire_bit,
  output logic done_ok
);
  logic pend_q, busy_q, fire_q;

  assign done_ok     = done && busy_q && !pend_q;
  assign start_valid = pend_q;
  assign busy        = busy_q;
  assign fire_bit    = fire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      if (fire_req && !busy_q) begin
        pend_q <= 1'b1;
        busy_q <= 1'b1;
        fire_q <= 1'b1;
      end else begin
        if (pend_q && start_ready) pend_q <= 1'b0;
        if (done_ok)               busy_q <= 1'b0;
      end
      if (fire_clr) fire_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sbw_irq_unit.sv
module sbw_irq_unit #(
  parameter int N  = 5,
  parameter int RW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [N-1:0]  set_vec,
  input  logic [RW-1:0] res_in,
  input  logic          clr_en,
  input  logic [N-1:0]  clr_vec,
  input  logic [N-1:0]  enable,
  output logic [N-1:0]  sts,
  output logic [RW-1:0] res,
  output logic          irq
);
  logic [N-1:0] clr_m, set_m;
  assign clr_m = clr_en ? clr_vec : '0;
  assign set_m = set_en ? set_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      res <= '0;
    end else begin
      sts <= (sts & ~clr_m) | set_m;
      if (set_en) res <= res_in;
    end
  end

  assign irq = |(sts & enable);
endmodule

// File: rtl/sbw_host_regs.sv
module sbw_host_regs
  import sbw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_wen,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic [DW-1:0]        cfg_ctrl,
  output logic [15:0]          cfg_timing,
  output logic [1:0]           cfg_nego_mode,
  output logic [23:0]          cfg_exp_fcs,
  output logic [LEN_W-1:0]     eng_target,
  output logic [LEN_W-1:0]     eng_wr_len,
  output logic [LEN_W-1:0]     eng_rd_len,
  output logic                 eng_auto_fcs,
  output logic [BUF_BYTES*8-1:0] eng_tx_data,
  output logic                 eng_start_valid,
  input  logic                 eng_start_ready,
  input  logic                 eng_done,
  input  logic [NSTS-2:0]      eng_flags,
  input  logic [NEGO_W-1:0]    eng_nego_result,
  input  logic [7:0]           eng_cap_wfcs,
  input  logic [7:0]           eng_cap_rfcs,
  input  logic [BUF_BYTES*8-1:0] eng_rx_data,
  input  logic [3:0]           eng_state,
  input  logic                 eng_pin_mon,
  output logic                 irq
);
  logic [DW-1:0] ctrl_q, timing_q, len_q, exp_q, intctl_q;
  logic [7:0]    cap_w_q, cap_r_q;
  logic          busy, fire_bit, done_ok;
  logic [NSTS-1:0]   st_bits;
  logic [NEGO_W-1:0] nego_q;

  // write decode
  logic wr_cmd, wr_sts;
  assign wr_cmd = reg_wen && (reg_addr == A_CMD);
  assign wr_sts = reg_wen && (reg_addr == A_INTSTS);

  // buffer decode: tx banks at 0x20/0x40, rx banks at 0x30/0x50
  logic          tx_hit, rx_hit;
  logic [WIDX_W-1:0] buf_idx;
  assign tx_hit  = (reg_addr[1:0] == 2'b00) && !reg_addr[7] &&
                   ((reg_addr[6:4] == 3'b010) || (reg_addr[6:4] == 3'b100));
  assign rx_hit  = (reg_addr[1:0] == 2'b00) && !reg_addr[7] &&
                   ((reg_addr[6:4] == 3'b011) || (reg_addr[6:4] == 3'b101));
  assign buf_idx = {reg_addr[6], reg_addr[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      timing_q <= TIMING_RST;
      len_q    <= '0;
      exp_q    <= '0;
      intctl_q <= '0;
    end else if (reg_wen) begin
      unique case (reg_addr)
        A_CTRL:   ctrl_q   <= reg_wdata & CTRL_MASK;
        A_TIMING: timing_q <= reg_wdata & TIMING_MASK;
        A_LEN:    len_q    <= {reg_wdata[31], 7'd0,
                               clamp_len(reg_wdata[23:16]),
                               clamp_len(reg_wdata[15:8]),
                               reg_wdata[7:0]};
        A_EXPFCS: exp_q    <= reg_wdata & EXP_MASK;
        A_INTCTL: intctl_q <= reg_wdata & INTCTL_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_w_q <= '0;
      cap_r_q <= '0;
    end else if (done_ok) begin
      cap_w_q <= eng_cap_wfcs;
      cap_r_q <= eng_cap_rfcs;
    end
  end

  sbw_launch_ctl u_launch (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_req   (wr_cmd && reg_wdata[0]),
    .fire_clr   (wr_cmd && !reg_wdata[0]),
    .start_ready(eng_start_ready),
    .done       (eng_done),
    .start_valid(eng_start_valid),
    .busy       (busy),
    .fire_bit   (fire_bit),
    .done_ok    (done_ok)
  );

  sbw_irq_unit #(.N(NSTS), .RW(NEGO_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (done_ok),
    .set_vec({eng_flags, 1'b1}),
    .res_in (eng_nego_result),
    .clr_en (wr_sts),
    .clr_vec(reg_wdata[NSTS-1:0]),
    .enable (intctl_q[NSTS-1:0]),
    .sts    (st_bits),
    .res    (nego_q),
    .irq    (irq)
  );

  logic [BUF_BYTES*8-1:0] tx_flat, rx_flat;

  sbw_word_buf #(.WORDS(BUF_WORDS)) u_txbuf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wen && tx_hit),
    .wr_idx (buf_idx),
    .wr_data(reg_wdata),
    .ld_en  (1'b0),
    .ld_data('0),
    .flat   (tx_flat)
  );

  sbw_word_buf #(.WORDS(BUF_WORDS)) u_rxbuf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (1'b0),
    .wr_idx (buf_idx),
    .wr_data(reg_wdata),
    .ld_en  (done_ok),
    .ld_data(eng_rx_data),
    .flat   (rx_flat)
  );

  always_comb begin
    reg_rdata = '0;
    if (tx_hit)      reg_rdata = tx_flat[buf_idx*32 +: 32];
    else if (rx_hit) reg_rdata = rx_flat[buf_idx*32 +: 32];
    else begin
      case (reg_addr)
        A_CTRL:   reg_rdata = ctrl_q;
        A_TIMING: reg_rdata = timing_q;
        A_CMD:    reg_rdata = {eng_pin_mon, 3'b000, eng_state, 23'd0, fire_bit};
        A_LEN:    reg_rdata = len_q;
        A_EXPFCS: reg_rdata = exp_q;
        A_CAPFCS: reg_rdata = {8'd0, cap_r_q, 8'd0, cap_w_q};
        A_INTCTL: reg_rdata = intctl_q;
        A_INTSTS: reg_rdata = {2'b00, nego_q, 11'd0, st_bits};
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign cfg_ctrl      = ctrl_q;
  assign cfg_timing    = timing_q[15:0];
  assign cfg_nego_mode = intctl_q[31:30];
  assign cfg_exp_fcs   = exp_q[23:0];
  assign eng_target    = len_q[7:0];
  assign eng_wr_len    = len_q[15:8];
  assign eng_rd_len    = len_q[23:16];
  assign eng_auto_fcs  = len_q[31];
  assign eng_tx_data   = tx_flat;
endmodule

// File: rtl/sbw_host_regs_chk.sv
module sbw_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wen,
  input logic [7:0] reg_addr,
  input logic       clr_bit0,
  input logic       eng_start_valid,
  input logic       eng_start_ready,
  input logic       eng_done,
  input logic       busy,
  input logic       done_bit,
  input logic [7:0] eng_wr_len,
  input logic [7:0] eng_rd_len
);
  // R5
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_valid && !eng_start_ready |=> eng_start_valid);

  // R6
  idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_start_valid);

  // R7
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && busy && !eng_start_valid |=> done_bit);

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wen && (reg_addr == 8'h1C) && clr_bit0 && !(eng_done && busy && !eng_start_valid)
    |=> !done_bit);

  // R3
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_wr_len <= 8'd32) && (eng_rd_len <= 8'd32));
endmodule

bind sbw_host_regs sbw_host_regs_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wen        (reg_wen),
  .reg_addr       (reg_addr),
  .clr_bit0       (reg_wdata[0]),
  .eng_start_valid(eng_start_valid),
  .eng_start_ready(eng_start_ready),
  .eng_done       (eng_done),
  .busy           (busy),
  .done_bit       (st_bits[0]),
  .eng_wr_len     (eng_wr_len),
  .eng_rd_len     (eng_rd_len)
);

// File: tb/sbw_host_regs_test.sv
module sbw_host_regs_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [7:0]   reg_addr = 0;
  logic         reg_wen = 0;
  logic [31:0]  reg_wdata = 0;
  logic [31:0]  reg_rdata;
  logic [31:0]  cfg_ctrl;
  logic [15:0]  cfg_timing;
  logic [1:0]   cfg_nego_mode;
  logic [23:0]  cfg_exp_fcs;
  logic [7:0]   eng_target, eng_wr_len, eng_rd_len;
  logic         eng_auto_fcs;
  logic [255:0] eng_tx_data;
  logic         eng_start_valid;
  logic         eng_start_ready = 0;
  logic         eng_done = 0;
  logic [3:0]   eng_flags = 0;
  logic [13:0]  eng_nego_result = 0;
  logic [7:0]   eng_cap_wfcs = 0, eng_cap_rfcs = 0;
  logic [255:0] eng_rx_data = 0;
  logic [3:0]   eng_state = 0;
  logic         eng_pin_mon = 0;
  logic         irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sbw_host_regs uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1;
    @(negedge clk);
    reg_wen = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] rxb(input int n);
    return 8'(n * 3 + 1);
  endfunction

  // addr, write data, expected readback
  localparam logic [71:0] VEC [9] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h000F_3FF1},  // R2 control mask
    {8'h04, 32'h1234_5678, 32'h0000_5678},  // R2 timing mask
    {8'h18, 32'hFFFF_FFFF, 32'hC000_001F},  // R2 interrupt control mask
    {8'h10, 32'hAABB_CCDD, 32'h00BB_CCDD},  // R2 expected check mask
    {8'h0C, 32'h8028_215A, 32'h8020_205A},  // R3 clamp to 32
    {8'h0C, 32'h001F_0830, 32'h001F_0830},  // R2 length in range
    {8'h20, 32'h1122_3344, 32'h1122_3344},  // R4 low bank
    {8'h4C, 32'h5566_7788, 32'h5566_7788},  // R4 high bank
    {8'h30, 32'hDEAD_BEEF, 32'h0000_0000}   // R8 rx ignores writes
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int n = 0; n < 32; n++) eng_rx_data[8*n +: 8] = rxb(n);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, r); chk("R1 ctrl", r, 32'h0008_0000);
    rd(8'h04, r); chk("R1 timing", r, 32'h0000_0101);
    rd(8'h1C, r); chk("R1 status", r, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 start_valid", {31'd0, eng_start_valid}, 32'd0);

    // table walk
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], r);
      chk($sformatf("R2/R3/R4/R8 vec%0d", i), r, VEC[i][31:0]);
    end
    chk("R3 wr_len out", {24'd0, eng_wr_len}, 32'h08);
    chk("R3 target out", {24'd0, eng_target}, 32'h30);
    chk("R4 tx byte0", {24'd0, eng_tx_data[7:0]}, 32'h44);
    chk("R4 tx byte3", {24'd0, eng_tx_data[31:24]}, 32'h11);
    chk("R4 tx byte28", {24'd0, eng_tx_data[231:224]}, 32'h88);
    chk("R4 tx byte31", {24'd0, eng_tx_data[255:248]}, 32'h55);

    // R5 launch with back-pressure
    wr(8'h18, 32'h0000_0001);
    wr(8'h08, 32'h1);
    chk("R5 valid rises", {31'd0, eng_start_valid}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 valid held", {31'd0, eng_start_valid}, 32'd1);
    eng_start_ready = 1;
    @(negedge clk);
    eng_start_ready = 0;
    chk("R5 valid drops", {31'd0, eng_start_valid}, 32'd0);

    // R6 clear fire bit, refire ignored while busy
    wr(8'h08, 32'h0);
    rd(8'h08, r); chk("R6 fire cleared", r, 32'h0);
    wr(8'h08, 32'h1);
    rd(8'h08, r); chk("R6 refire ignored bit", r, 32'h0);
    chk("R6 refire no launch", {31'd0, eng_start_valid}, 32'd0);

    // R7 completion
    eng_flags = 4'b0101; eng_nego_result = 14'h1ABC;
    eng_cap_wfcs = 8'h5E; eng_cap_rfcs = 8'hC3;
    eng_done = 1;
    @(negedge clk);
    eng_done = 0;
    rd(8'h1C, r); chk("R7 status", r, 32'h1ABC_000B);
    rd(8'h30, r); chk("R8 rx word0", r, {rxb(3), rxb(2), rxb(1), rxb(0)});
    rd(8'h50, r); chk("R8 rx word4", r, {rxb(19), rxb(18), rxb(17), rxb(16)});
    rd(8'h5C, r); chk("R8 rx word7", r, {rxb(31), rxb(30), rxb(29), rxb(28)});
    rd(8'h14, r); chk("R12 cap fcs", r, 32'h00C3_005E);
    chk("R10 irq on", {31'd0, irq}, 32'd1);

    // R10 masking
    wr(8'h18, 32'h0000_0010);
    chk("R10 masked", {31'd0, irq}, 32'd0);
    wr(8'h18, 32'h0000_0008);
    chk("R10 bit3 enabled", {31'd0, irq}, 32'd1);

    // R9 write-1-to-clear
    wr(8'h1C, 32'h0000_0003);
    rd(8'h1C, r); chk("R9 partial clear", r, 32'h1ABC_0008);
    wr(8'h1C, 32'h0000_001F);
    rd(8'h1C, r); chk("R9 full clear", r, 32'h1ABC_0000);
    chk("R10 irq off", {31'd0, irq}, 32'd0);

    // R7 done while idle ignored
    eng_flags = 4'hF; eng_nego_result = 14'h0033;
    for (int n = 0; n < 32; n++) eng_rx_data[8*n +: 8] = 8'hEE;
    eng_done = 1;
    @(negedge clk);
    eng_done = 0;
    rd(8'h1C, r); chk("R7 idle done ignored", r, 32'h1ABC_0000);
    rd(8'h30, r); chk("R7 idle rx kept", r, {rxb(3), rxb(2), rxb(1), rxb(0)});

    // R9 set beats clear in same cycle
    eng_start_ready = 1;
    wr(8'h08, 32'h1);
    @(negedge clk);
    eng_start_ready = 0;
    eng_flags = 4'h0; eng_nego_result = 14'h0005;
    reg_addr = 8'h1C; reg_wdata = 32'h1F; reg_wen = 1; eng_done = 1;
    @(negedge clk);
    reg_wen = 0; eng_done = 0;
    rd(8'h1C, r); chk("R9 set wins", r, 32'h0005_0001);

    // R11 command readback
    eng_state = 4'd3; eng_pin_mon = 1;
    rd(8'h08, r); chk("R11 cmd readback", r, 32'h8300_0001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule